// File: doc/BRIEF.md
# Single-Bit Test-and-Modify Unit

The unit picks one bit of an operand and either only reports it or reports it and then rewrites it. Four operations exist: test, test-and-invert, test-and-clear and test-and-set. The reported value is the zero condition flag. It is set when the chosen bit was 0 before the operation and cleared when that bit was 1. The other condition flags go through unchanged.

The position of the bit comes from one of two sources, chosen by an input: a short immediate field, or a full-width data register value. The operand is either a full register word or a byte taken from memory. A register operand uses the bit number modulo the register width. A byte operand uses it modulo eight. All higher bits of the bit number are ignored. For byte operands the result is zero-extended, so only its low byte carries data.

The unit accepts work through a valid/ready handshake. The result sits in a single output register and appears one cycle after acceptance. While the output is held, the unit takes no new work. Address generation, memory access and decoding of instructions are done elsewhere.

Top module: `bit_tam_unit`

## Requirements
- R1: In the cycle after `rst` is high, `res_valid` is 0. While `res_valid` is 0, `req_ready` is 1.
- R2: In the result of every operation, bit Z_POS (default 2) of `flags_out` is the complement of the addressed operand bit as it was before the operation.
- R3: When `op` = 0 (test), `result` equals the operand. For a byte operand, that operand is the low 8 bits of `operand`, zero-extended.
- R4: The other operations change only the addressed bit. `op` = 1 inverts it, `op` = 2 writes 0 and `op` = 3 writes 1.
- R5: When `bn_from_reg` = 1 the bit number is `reg_bitnum`. When it is 0 the bit number is `imm_bitnum`. The unselected source has no effect.
- R6: For a register operand (`is_byte` = 0) the addressed bit is the bit number modulo 32. Bit-number bits above bit 4 are ignored.
- R7: For a byte operand (`is_byte` = 1) the addressed bit is the bit number modulo 8. Bits 31..8 of `result` are 0, and bits 31..8 of `operand` have no effect.
- R8: Every bit of `flags_out` except Z_POS equals the matching bit of `flags_in` at acceptance.
- R9: A request is accepted when `req_valid` and `req_ready` are both 1. Its outputs appear with `res_valid` = 1 one cycle later. `req_ready` = !`res_valid` || `res_ready`. While `res_valid` is 1 and `res_ready` is 0, the outputs do not change and new requests are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| op | input | 2 | 0 test, 1 invert, 2 clear, 3 set |
| operand | input | 32 | Operand word; only the low 8 bits are used for a byte operand |
| is_byte | input | 1 | 1 = byte memory operand, 0 = register operand |
| bn_from_reg | input | 1 | 1 = bit number from `reg_bitnum`, 0 = from `imm_bitnum` |
| imm_bitnum | input | 8 | Immediate bit number |
| reg_bitnum | input | 32 | Data-register bit number |
| flags_in | input | 5 | Condition flags before the operation |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Modified operand |
| flags_out | output | 5 | Flags with the zero flag updated |

## Verification
The assertions run on every cycle. They check that no bit outside the addressed one changes, and that a test returns its operand unchanged. They also check that the non-zero flags pass through, that the upper bits of a byte result are zero, that a stalled result holds steady, and that reset empties the output. Some behaviour needs the bench's scenarios, which sweep every operation, operand kind, bit-number source and bit number from 0 to 63 against arithmetic expectations. Those scenarios show that the zero flag has the right polarity, that the modulo-32 and modulo-8 wrapping picks the right bit, that the unselected source is ignored, and that a request offered during a stall is refused.

// File: rtl/btm_pkg.sv
package btm_pkg;
   typedef enum logic [1:0] {
      BTM_TEST = 2'd0,
      BTM_INV  = 2'd1,
      BTM_CLR  = 2'd2,
      BTM_SET  = 2'd3
   } btm_op_e;
endpackage

// File: rtl/btm_index.sv
// Bit-number source selection, width-dependent wrap and one-hot decode.
module btm_index #(
   parameter int REG_W = 32,
   parameter int MEM_W = 8,
   parameter int IMM_W = 8
) (
   input  logic [IMM_W-1:0] imm_bn,
   input  logic [REG_W-1:0] reg_bn,
   input  logic             use_reg,
   input  logic             is_byte,
   output logic [REG_W-1:0] mask
);
   localparam int RIDX = $clog2(REG_W);
   localparam int MIDX = $clog2(MEM_W);
   localparam logic [RIDX-1:0] REG_LIM = RIDX'(REG_W - 1);
   localparam logic [RIDX-1:0] MEM_LIM = RIDX'(MEM_W - 1);

   if (REG_W != (1 << RIDX)) begin : g_bad_reg_w
      $error("REG_W must be a power of two");
   end
   if (MEM_W != (1 << MIDX) || MEM_W > REG_W) begin : g_bad_mem_w
      $error("MEM_W must be a power of two not above REG_W");
   end
   if (IMM_W < RIDX) begin : g_bad_imm_w
      $error("IMM_W too narrow to address REG_W bits");
   end

   logic [RIDX-1:0] raw_idx;
   logic [RIDX-1:0] idx;

   always_comb begin
      raw_idx = use_reg ? reg_bn[RIDX-1:0] : imm_bn[RIDX-1:0];
      idx     = raw_idx & (is_byte ? MEM_LIM : REG_LIM);
   end

   for (genvar i = 0; i < REG_W; i++) begin : g_dec
      assign mask[i] = (idx == RIDX'(i));
   end

   // decoder yields exactly one addressed bit, inside the byte for byte operands (R6, R7)
   always_comb begin
      if (!$isunknown({use_reg, is_byte, imm_bn, reg_bn})) begin
         p_onehot_mask_r6: assert ($countones(mask) == 1);
         p_byte_range_r7: assert (!is_byte || ((mask >> MEM_W) == '0));
      end
   end
endmodule

// File: rtl/btm_alu.sv
// Operand masking, zero-flag derivation and single-bit rewrite.
module btm_alu
   import btm_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int MEM_W    = 8,
   parameter bit PER_BIT  = 1'b1
) (
   input  logic [REG_W-1:0] operand,
   input  logic [REG_W-1:0] mask,
   input  logic             is_byte,
   input  btm_op_e          op,
   output logic [REG_W-1:0] result,
   output logic             zero
);
   localparam logic [REG_W-1:0] HI_BITS = {REG_W{1'b1}} << MEM_W;

   logic [REG_W-1:0] opnd;

   always_comb begin
      opnd = is_byte ? (operand & ~HI_BITS) : operand;
      zero = ~|(opnd & mask);
   end

   if (PER_BIT) begin : g_per_bit
      for (genvar i = 0; i < REG_W; i++) begin : g_bit
         always_comb begin
            if (!mask[i]) begin
               result[i] = opnd[i];
            end else begin
               unique case (op)
                  BTM_TEST: result[i] = opnd[i];
                  BTM_INV:  result[i] = ~opnd[i];
                  BTM_CLR:  result[i] = 1'b0;
                  default:  result[i] = 1'b1;
               endcase
            end
         end
      end
   end else begin : g_word
      always_comb begin
         unique case (op)
            BTM_TEST: result = opnd;
            BTM_INV:  result = opnd ^ mask;
            BTM_CLR:  result = opnd & ~mask;
            default:  result = opnd | mask;
         endcase
      end
   end

   // only the addressed bit may differ from the masked operand (R4)
   always_comb begin
      if (!$isunknown({operand, mask, is_byte, op})) begin
         p_only_addressed_r4: assert (((result ^ opnd) & ~mask) == '0);
         p_set_writes_one_r4: assert (op != BTM_SET || ((result & mask) == mask));
         p_clr_writes_zero_r4: assert (op != BTM_CLR || ((result & mask) == '0));
      end
   end
endmodule

// File: rtl/btm_oreg.sv
// Single-entry result register with valid/ready handshake.
module btm_oreg #(
   parameter int REG_W  = 32,
   parameter int MEM_W  = 8,
   parameter int FLAG_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [REG_W-1:0]  d_result,
   input  logic [FLAG_W-1:0] d_flags,
   input  logic              d_byte,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [REG_W-1:0]  q_result,
   output logic [FLAG_W-1:0] q_flags
);
   localparam logic [REG_W-1:0] HI_BITS = {REG_W{1'b1}} << MEM_W;

   logic q_byte;
   logic load;

   assign in_ready = !out_valid || out_ready;
   assign load     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         q_result  <= '0;
         q_flags   <= '0;
         q_byte    <= 1'b0;
      end else begin
         if (load) begin
            out_valid <= 1'b1;
            q_result  <= d_result;
            q_flags   <= d_flags;
            q_byte    <= d_byte;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   p_empty_after_reset_r1: assert property (@(posedge clk) rst |=> !out_valid);

   p_hold_when_stalled_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(q_result) && $stable(q_flags)));

   p_accept_shows_next_r9: assert property (@(posedge clk) disable iff (rst)
      load |=> out_valid);

   p_byte_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && q_byte) |-> ((q_result & HI_BITS) == '0));
endmodule

// File: rtl/bit_tam_unit.sv
// Top: single-bit test-and-modify with registered result.
module bit_tam_unit
   import btm_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int MEM_W   = 8,
   parameter int IMM_W   = 8,
   parameter int FLAG_W  = 5,
   parameter int Z_POS   = 2,
   parameter bit PER_BIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        op,
   input  logic [REG_W-1:0]  operand,
   input  logic              is_byte,
   input  logic              bn_from_reg,
   input  logic [IMM_W-1:0]  imm_bitnum,
   input  logic [REG_W-1:0]  reg_bitnum,
   input  logic [FLAG_W-1:0] flags_in,
   output logic              res_valid,
   input  logic              res_ready,
   output logic [REG_W-1:0]  result,
   output logic [FLAG_W-1:0] flags_out
);
   localparam logic [FLAG_W-1:0] Z_MASK  = FLAG_W'(1) << Z_POS;
   localparam logic [REG_W-1:0]  HI_BITS = {REG_W{1'b1}} << MEM_W;

   if (Z_POS < 0 || Z_POS >= FLAG_W) begin : g_bad_z_pos
      $error("Z_POS outside flag word");
   end

   logic [REG_W-1:0]  bit_mask;
   logic [REG_W-1:0]  alu_res;
   logic              alu_zero;
   logic [FLAG_W-1:0] next_flags;
   btm_op_e           op_e;

   assign op_e = btm_op_e'(op);

   btm_index #(.REG_W(REG_W), .MEM_W(MEM_W), .IMM_W(IMM_W)) u_index (
      .imm_bn  (imm_bitnum),
      .reg_bn  (reg_bitnum),
      .use_reg (bn_from_reg),
      .is_byte (is_byte),
      .mask    (bit_mask)
   );

   btm_alu #(.REG_W(REG_W), .MEM_W(MEM_W), .PER_BIT(PER_BIT)) u_alu (
      .operand (operand),
      .mask    (bit_mask),
      .is_byte (is_byte),
      .op      (op_e),
      .result  (alu_res),
      .zero    (alu_zero)
   );

   assign next_flags = (flags_in & ~Z_MASK) | (alu_zero ? Z_MASK : '0);

   btm_oreg #(.REG_W(REG_W), .MEM_W(MEM_W), .FLAG_W(FLAG_W)) u_oreg (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (req_valid),
      .in_ready  (req_ready),
      .d_result  (alu_res),
      .d_flags   (next_flags),
      .d_byte    (is_byte),
      .out_valid (res_valid),
      .out_ready (res_ready),
      .q_result  (result),
      .q_flags   (flags_out)
   );

   p_flags_pass_r8: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> ((flags_out & ~Z_MASK) == ($past(flags_in) & ~Z_MASK)));

   p_test_keeps_operand_r3: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && op == 2'd0) |=>
      (result == ($past(is_byte) ? ($past(operand) & ~HI_BITS) : $past(operand))));

   p_ready_rule_r9: assert property (@(posedge clk) disable iff (rst)
      !res_valid |-> req_ready);
endmodule

// File: tb/sim_bit_tam_unit.sv
`timescale 1ns/1ps
module sim_bit_tam_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid, req_ready;
   logic [1:0]  op;
   logic [31:0] operand;
   logic        is_byte, bn_from_reg;
   logic [7:0]  imm_bitnum;
   logic [31:0] reg_bitnum;
   logic [4:0]  flags_in;
   logic        res_valid, res_ready;
   logic [31:0] result;
   logic [4:0]  flags_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bit_tam_unit u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .op(op), .operand(operand), .is_byte(is_byte), .bn_from_reg(bn_from_reg),
      .imm_bitnum(imm_bitnum), .reg_bitnum(reg_bitnum), .flags_in(flags_in),
      .res_valid(res_valid), .res_ready(res_ready), .result(result),
      .flags_out(flags_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (op=%0d byte=%0b src=%0b imm=%0d reg=%h opnd=%h)",
                  tag, act, exp, op, is_byte, bn_from_reg, imm_bitnum, reg_bitnum, operand);
      end
   endtask

   // one request through a free output; expected values computed from the requirements
   task automatic run_one(input logic [1:0] o, input logic [31:0] d, input logic byt,
                          input logic src, input logic [7:0] ib, input logic [31:0] rb,
                          input logic [4:0] fl);
      logic [31:0] eff, expr, bnum;
      int idx;
      logic b;
      string tag;
      @(negedge clk);
      op = o; operand = d; is_byte = byt; bn_from_reg = src;
      imm_bitnum = ib; reg_bitnum = rb; flags_in = fl; req_valid = 1'b1;
      bnum = src ? rb : {24'd0, ib};                  // R5 source choice
      idx  = byt ? int'(bnum % 8) : int'(bnum % 32);  // R6 / R7 wrap
      eff  = byt ? (d & 32'h0000_00FF) : d;
      b    = eff[idx];
      expr = eff;
      case (o)
         2'd1: expr[idx] = ~b;
         2'd2: expr[idx] = 1'b0;
         2'd3: expr[idx] = 1'b1;
         default: ;
      endcase
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 res_valid after accept", {31'd0, res_valid}, 32'd1);
      if (o == 2'd0) tag = "R3 test result";
      else           tag = "R4 modify result";
      if (byt)       tag = {tag, " R7 byte"};
      else           tag = {tag, " R6 reg"};
      if (src)       tag = {tag, " R5 from reg"};
      else           tag = {tag, " R5 from imm"};
      check(tag, result, expr);
      check("R2 zero flag", {31'd0, flags_out[2]}, {31'd0, ~b});
      check("R8 other flags", {27'd0, flags_out & 5'b11011}, {27'd0, fl & 5'b11011});
   endtask

   initial begin
      logic [31:0] pats [4];
      pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'hA5C3_3C5A; pats[3] = 32'h1234_56E9;
      rst = 1'b1; req_valid = 1'b0; res_ready = 1'b1;
      op = '0; operand = '0; is_byte = 1'b0; bn_from_reg = 1'b0;
      imm_bitnum = '0; reg_bitnum = '0; flags_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 res_valid in reset", {31'd0, res_valid}, 32'd0);
      check("R1 req_ready in reset", {31'd0, req_ready}, 32'd1);
      rst = 1'b0;

      for (int o = 0; o < 4; o++)
         for (int k = 0; k < 2; k++)
            for (int s = 0; s < 2; s++)
               for (int n = 0; n < 64; n++)
                  for (int p = 0; p < 4; p++) begin
                     // the unselected source carries a different, misleading number (R5)
                     logic [7:0]  ib = s ? 8'(n + 3) : 8'(n | (p << 6));
                     logic [31:0] rb = s ? (32'(n) | (32'(p) << 29)) : 32'(n + 5);
                     run_one(2'(o), pats[p], 1'(k), 1'(s), ib, rb, 5'(n + p * 7));
                  end

      // wide register bit number: upper bits ignored (R6), and byte wrap (R7)
      run_one(2'd3, 32'h0, 1'b0, 1'b1, 8'd0, 32'hFFFF_FFE5, 5'h1F);
      run_one(2'd1, 32'hFFFF_FF00, 1'b1, 1'b1, 8'd0, 32'h8000_000F, 5'h00);

      // stall: result held, new request refused (R9)
      @(negedge clk);
      res_ready = 1'b0;
      op = 2'd3; operand = 32'h0; is_byte = 1'b0; bn_from_reg = 1'b0;
      imm_bitnum = 8'd9; flags_in = 5'h00; req_valid = 1'b1;
      @(negedge clk);
      op = 2'd2; operand = 32'hFFFF_FFFF; imm_bitnum = 8'd1; flags_in = 5'h1B;
      for (int c = 0; c < 3; c++) begin
         check("R9 stalled res_valid", {31'd0, res_valid}, 32'd1);
         check("R9 stalled req_ready", {31'd0, req_ready}, 32'd0);
         check("R9 stalled result", result, 32'h0000_0200);
         check("R9 stalled flags", {27'd0, flags_out}, 32'h0000_0004);
         @(negedge clk);
      end
      res_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 second request after release", result, 32'hFFFF_FFFD);
      check("R9 second flags", {27'd0, flags_out}, 32'h0000_001B);
      @(negedge clk);
      check("R9 drained", {31'd0, res_valid}, 32'd0);

      // reset while full empties the output (R1)
      @(negedge clk);
      req_valid = 1'b1; res_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      check("R1 reset clears res_valid", {31'd0, res_valid}, 32'd0);
      rst = 1'b0;
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule